// File: doc/BRIEF.md
# Port Input Debouncer

This block filters the eight input lines of one general-purpose I/O port so that contact bounce and short glitches do not reach the logic reading them. Every raw line first crosses into the clock domain through a two-stage synchronizer. A single stability time, in milliseconds, is held in one register for the whole port. Each line has its own enable bit that selects whether it is filtered. A filtered line changes its reported level only after the synchronized input has sat at the new level for that many millisecond ticks. A line that is not filtered follows the synchronized input directly.

The millisecond timing comes from a one-cycle `ms_tick` pulse produced elsewhere. The stability time is loaded with a plain write strobe. The enable bits are updated with a masked write: the upper half of the write word selects the lines to change and the lower half carries their new values. This lets each line be configured without a read-modify-write.

Top module: `port_debounce`

## Requirements
- R1: While `rst` is high, each output takes the synchronized raw level. With `rst` held for at least three clocks, `pin_out` equals `raw_in` when reset is released. The stability time resets to 0 and every enable bit resets to 0.
- R2: A line that is not filtered shows a change of `raw_in` on `pin_out` three clock edges after the change: two synchronizer stages followed by the output register.
- R3: A line whose enable bit is 0 passes through unfiltered, whatever the stored stability time is.
- R4: A stability time of 0 turns filtering off for every line, even for lines whose enable bit is 1.
- R5: A filtered line whose synchronized input differs from its output takes the new level at the clock edge where the Nth `ms_tick` of that mismatch is seen, with N equal to the stored time. Without ticks it holds its level.
- R6: When a filtered line's input returns to the output level before N ticks have passed, the output does not change. Its tick count restarts from zero for the next mismatch.
- R7: A write with `en_we` high sets enable bit i to `en_wdata[i]` only where the mask bit `en_wdata[8+i]` is 1. Enable bits with a 0 mask bit keep their value.
- R8: A write with `cnt_we` high loads `cnt_wdata` as the stability time, and that single value applies to all eight lines at once.
- R9: Stability times up to 255 are honoured exactly. With 255, a line changes on the 255th tick and not on the 254th, and its counter never wraps.
- R10: Each line keeps its own tick count. Lines whose mismatches start at different times change at different ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ms_tick | input | 1 | One-cycle pulse once per millisecond |
| raw_in | input | 8 | Asynchronous raw port inputs |
| cnt_we | input | 1 | Load strobe for the stability time |
| cnt_wdata | input | 8 | New stability time in milliseconds |
| en_we | input | 1 | Masked write strobe for the enable bits |
| en_wdata | input | 16 | [15:8] mask of lines to update, [7:0] new enable values |
| pin_out | output | 8 | Debounced port levels |

## Verification
The bench counts ticks against the programmed time and checks the output one tick before the change and again at the tick where it must happen. A filter that is off by one would switch early or late here. A glitch shorter than the stability time is followed by a second short glitch. A counter that fails to restart would then let the second glitch through. A masked enable write that changes only half the lines is checked by driving all eight lines and seeing which of them follow at once; a write that ignored the mask would filter the wrong half. A zero stability time with enables set, and the full 255-tick time, cover the two ends of the count range.

// File: rtl/gdb_pkg.sv
package gdb_pkg;
  localparam int unsigned DEF_PINS   = 8;
  localparam int unsigned DEF_CNT_W  = 8;
  localparam int unsigned DEF_STAGES = 2;

  // True when one more tick brings the running count to the limit.
  function automatic logic last_tick(input logic [15:0] cnt, input logic [15:0] lim);
    return ({1'b0, cnt} + 17'd1) >= {1'b0, lim};
  endfunction
endpackage

// File: rtl/gdb_sync.sv
module gdb_sync #(
  parameter int unsigned PINS   = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic            clk,
  input  logic [PINS-1:0] async_in,
  output logic [PINS-1:0] sync_out
);
  logic [PINS-1:0] chain [STAGES];

  // Plain flop chain with no reset: the output register clears through it.
  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) chain[s] <= async_in;
      end else begin : g_next
        always_ff @(posedge clk) chain[s] <= chain[s-1];
      end
    end
  endgenerate

  assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/gdb_cfg.sv
module gdb_cfg #(
  parameter int unsigned PINS  = 8,
  parameter int unsigned CNT_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cnt_we,
  input  logic [CNT_W-1:0]  cnt_wdata,
  input  logic              en_we,
  input  logic [2*PINS-1:0] en_wdata,
  output logic [CNT_W-1:0]  limit,
  output logic [PINS-1:0]   en_q
);
  logic [PINS-1:0] wmask, wval;
  assign wmask = en_wdata[2*PINS-1:PINS];
  assign wval  = en_wdata[PINS-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      limit <= '0;
      en_q  <= '0;
    end else begin
      if (cnt_we) limit <= cnt_wdata;
      if (en_we)  en_q  <= (en_q & ~wmask) | (wval & wmask);
    end
  end

  // R7: lines outside the mask keep their enable bit across a write.
  a_r7_mask_keeps: assert property (@(posedge clk) disable iff (rst)
    en_we |=> (((en_q ^ $past(en_q)) & ~$past(wmask)) == '0));
  // R8: the stability time changes only on a load strobe.
  a_r8_count_hold: assert property (@(posedge clk) disable iff (rst)
    !cnt_we |=> $stable(limit));
endmodule

// File: rtl/gdb_pin_filter.sv
module gdb_pin_filter #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             enable,
  input  logic [CNT_W-1:0] limit,
  input  logic             level_in,
  output logic             level_out
);
  import gdb_pkg::*;

  logic [CNT_W-1:0] run_cnt;
  logic             active;
  logic             done;

  assign active = enable && (limit != '0);
  assign done   = last_tick(16'(run_cnt), 16'(limit));

  always_ff @(posedge clk) begin
    if (rst || !active) begin
      level_out <= level_in;
      run_cnt   <= '0;
    end else if (level_in == level_out) begin
      run_cnt <= '0;
    end else if (tick) begin
      if (done) begin
        level_out <= level_in;
        run_cnt   <= '0;
      end else begin
        run_cnt <= run_cnt + 1'b1;
      end
    end
  end

  // R3 and R4: with filtering off the output copies the input one edge later.
  a_r3_passthru: assert property (@(posedge clk) disable iff (rst)
    !active |=> (level_out == $past(level_in)));
  // R5: a filtered line never moves on a cycle without a tick.
  a_r5_hold_no_tick: assert property (@(posedge clk) disable iff (rst)
    (active && !tick) |=> $stable(level_out));
  // R6: agreement between input and output restarts the count.
  a_r6_restart: assert property (@(posedge clk) disable iff (rst)
    (level_in == level_out) |=> (run_cnt == '0));
  // R9: the running count never reaches the all-ones value.
  a_r9_no_overflow: assert property (@(posedge clk) disable iff (rst)
    run_cnt != '1);
endmodule

// File: rtl/port_debounce.sv
module port_debounce #(
  parameter int unsigned PINS   = gdb_pkg::DEF_PINS,
  parameter int unsigned CNT_W  = gdb_pkg::DEF_CNT_W,
  parameter int unsigned STAGES = gdb_pkg::DEF_STAGES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ms_tick,
  input  logic [PINS-1:0]   raw_in,
  input  logic              cnt_we,
  input  logic [CNT_W-1:0]  cnt_wdata,
  input  logic              en_we,
  input  logic [2*PINS-1:0] en_wdata,
  output logic [PINS-1:0]   pin_out
);
  logic [PINS-1:0]  synced;
  logic [PINS-1:0]  en_q;
  logic [CNT_W-1:0] limit;

  gdb_sync #(.PINS(PINS), .STAGES(STAGES)) u_sync (
    .clk      (clk),
    .async_in (raw_in),
    .sync_out (synced)
  );

  gdb_cfg #(.PINS(PINS), .CNT_W(CNT_W)) u_cfg (
    .clk       (clk),
    .rst       (rst),
    .cnt_we    (cnt_we),
    .cnt_wdata (cnt_wdata),
    .en_we     (en_we),
    .en_wdata  (en_wdata),
    .limit     (limit),
    .en_q      (en_q)
  );

  generate
    for (genvar p = 0; p < PINS; p++) begin : g_pin
      gdb_pin_filter #(.CNT_W(CNT_W)) u_filt (
        .clk       (clk),
        .rst       (rst),
        .tick      (ms_tick),
        .enable    (en_q[p]),
        .limit     (limit),
        .level_in  (synced[p]),
        .level_out (pin_out[p])
      );
    end
  endgenerate
endmodule

// File: tb/port_debounce_bench.sv
module port_debounce_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ms_tick = 1'b0;
  logic [7:0]  raw_in = 8'h00;
  logic        cnt_we = 1'b0;
  logic [7:0]  cnt_wdata = 8'h00;
  logic        en_we = 1'b0;
  logic [15:0] en_wdata = 16'h0000;
  logic [7:0]  pin_out;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  port_debounce u_port_debounce (
    .clk(clk), .rst(rst), .ms_tick(ms_tick), .raw_in(raw_in),
    .cnt_we(cnt_we), .cnt_wdata(cnt_wdata), .en_we(en_we),
    .en_wdata(en_wdata), .pin_out(pin_out)
  );

  task automatic check(input string req, input logic [7:0] exp);
    checks++;
    if (pin_out !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, pin_out, exp);
    end
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse_tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) ms_tick = 1'b1;
      @(negedge clk) ms_tick = 1'b0;
    end
  endtask

  task automatic write_count(input logic [7:0] v);
    @(negedge clk) begin cnt_we = 1'b1; cnt_wdata = v; end
    @(negedge clk) cnt_we = 1'b0;
  endtask

  task automatic write_en(input logic [15:0] w);
    @(negedge clk) begin en_we = 1'b1; en_wdata = w; end
    @(negedge clk) en_we = 1'b0;
  endtask

  task automatic set_raw(input logic [7:0] v, input int settle);
    @(negedge clk) raw_in = v;
    cycles(settle);
  endtask

  task automatic t_reset;
    raw_in = 8'hA5;
    cycles(5);
    rst = 1'b0;
    check("R1 reset follows raw", 8'hA5);
  endtask

  task automatic t_passthrough;
    write_count(8'd3);
    @(negedge clk) raw_in = 8'h5A;
    cycles(2);
    check("R2 not yet after two edges", 8'hA5);
    cycles(1);
    check("R2 R3 arrives on third edge", 8'h5A);
    set_raw(8'h00, 4);
    check("R3 disabled lines follow", 8'h00);
  endtask

  task automatic t_zero_count;
    write_count(8'd0);
    write_en(16'hFFFF);
    @(negedge clk) raw_in = 8'h3C;
    cycles(3);
    check("R4 zero time passes through", 8'h3C);
    set_raw(8'h00, 4);
    check("R4 zero time back low", 8'h00);
  endtask

  task automatic t_filter;
    write_count(8'd3);
    set_raw(8'h01, 4);
    check("R5 held without ticks", 8'h00);
    pulse_tick(2);
    check("R5 held after two ticks", 8'h00);
    pulse_tick(1);
    check("R5 changes on third tick", 8'h01);
  endtask

  task automatic t_glitch;
    set_raw(8'h00, 4);
    pulse_tick(2);
    check("R6 short glitch ignored", 8'h01);
    set_raw(8'h01, 4);
    set_raw(8'h00, 4);
    pulse_tick(2);
    check("R6 count restarted", 8'h01);
    pulse_tick(1);
    check("R6 full time accepted", 8'h00);
  endtask

  task automatic t_mask;
    write_en({8'h0F, 8'h00});
    set_raw(8'hFF, 4);
    check("R7 masked lines freed", 8'h0F);
    pulse_tick(3);
    check("R7 filtered lines settle", 8'hFF);
    write_en({8'h00, 8'hFF});
    set_raw(8'h00, 4);
    check("R7 zero mask changes nothing", 8'hF0);
    pulse_tick(3);
    check("R7 upper lines settle", 8'h00);
    write_en(16'hFFFF);
  endtask

  task automatic t_independent;
    write_count(8'd4);
    set_raw(8'h01, 4);
    pulse_tick(2);
    set_raw(8'h03, 4);
    pulse_tick(2);
    check("R10 R8 first line done", 8'h01);
    pulse_tick(2);
    check("R10 second line done", 8'h03);
  endtask

  task automatic t_max;
    write_count(8'd255);
    set_raw(8'h00, 4);
    pulse_tick(254);
    check("R9 held at 254 ticks", 8'h03);
    pulse_tick(1);
    check("R9 R8 change at 255 ticks", 8'h00);
  endtask

  initial begin
    t_reset();
    t_passthrough();
    t_zero_count();
    t_filter();
    t_glitch();
    t_mask();
    t_independent();
    t_max();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule